// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer that software drives through a small byte-addressed register file. Once the halt bit is cleared, a prescaler produces one tick every `CLKS_PER_TICK` clock cycles. A 6-bit down-counter steps down by one on each tick, starting from a programmable initial value. Software keeps the system alive by writing the reload register, which restarts the countdown from the initial value.

Expiry is handled in two stages. When the counter runs out for the first time, the counter reloads itself and keeps running. At the same time the block sets a timeout flag and, if the interrupt is enabled, records and raises an interrupt. If the counter runs out again while that timeout flag is still set, the block sets a second-timeout flag and pulses the system-reset output for one cycle. A strap input suppresses that pulse.

All status flags are cleared by writing a one to them. A boot flag comes up set after reset.

Top module: `wdog_two_stage`

## Requirements
- R1: After synchronous reset the halt bit (offset 0x08, bit 11) reads 1, the count and the initial value (offsets 0x00 and 0x01) read `INIT_RST`, every status bit reads 0 except the boot flag, and `irq` and `sys_rst_pulse` are low.
- R2: Any write to offset 0x00, whatever the data, loads the count from the initial value at the next clock edge and restarts the prescaler. A read of offset 0x00 returns the current count in bits 5:0.
- R3: While running, the count steps down by one every `CLKS_PER_TICK` cycles. Counting from the reload edge, expiry happens at edge `init*CLKS_PER_TICK`. The count never reads 0.
- R4: While bit 11 of offset 0x08 is 1, the count and the prescaler hold their values. Writing that bit as 0 lets counting resume.
- R5: Bit 9 of offset 0x08 is preserved: writes never change it, and it reads 0. All other control bits except bit 11 read 0.
- R6: A write to offset 0x01 stores `wr_data[5:0]` as the initial value. A value of 0 or 1 is stored as 2. The new value takes effect only at the next reload or expiry.
- R7: At an expiry the counter reloads from the initial value and keeps counting, and bit 3 of offset 0x04 (first-timeout flag) becomes 1.
- R8: The status flags (0x04 bit 3; 0x06 bits 1 and 2; 0x0C bit 13) are cleared by writing a 1 to them. Writing a 0 has no effect. If a flag is set and cleared in the same cycle, the set wins.
- R9: Bit 2 of offset 0x06 (boot flag) reads 1 after reset and is cleared only by writing a 1 to it.
- R10: Bit 13 of offset 0x0A is the interrupt enable. An expiry that finds the first-timeout flag clear, with the enable set, sets bit 13 of offset 0x0C. `irq` is high while that status bit and the enable are both 1.
- R11: An expiry that finds the first-timeout flag already set sets bit 1 of offset 0x06 and drives `sys_rst_pulse` high for exactly the one cycle after that edge.
- R12: If `strap_no_reset` is high at that second-stage expiry, `sys_rst_pulse` stays low, but the second-timeout flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write byte offset |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read byte offset |
| rd_data | output | 16 | Register read data (combinational from state) |
| strap_no_reset | input | 1 | Strap that blocks the system-reset pulse |
| irq | output | 1 | Timeout interrupt (level) |
| sys_rst_pulse | output | 1 | One-cycle system-reset request |

## Verification
Register writes take effect at the clock edge that samples them. Flags, count, `irq` and `sys_rst_pulse` all change at the edge where the expiry tick is seen, which is `init*CLKS_PER_TICK` edges after a reload. Reads are combinational, so a value is visible in the half cycle after the edge that produced it. The bench changes inputs just after each rising edge. Its behavioural model advances on the rising edge and is compared with the outputs at every falling edge. Directed reads are placed on counted edges, so each one samples before or after a known tick or expiry, never on it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Byte offsets decoded by software
    localparam logic [3:0] OFS_RELOAD = 4'h0;
    localparam logic [3:0] OFS_INIT   = 4'h1;
    localparam logic [3:0] OFS_STS1   = 4'h4;
    localparam logic [3:0] OFS_STS2   = 4'h6;
    localparam logic [3:0] OFS_CTRL   = 4'h8;
    localparam logic [3:0] OFS_IEN    = 4'hA;
    localparam logic [3:0] OFS_ISTS   = 4'hC;

    // Bit positions software relies on
    localparam int BIT_FIRST  = 3;
    localparam int BIT_SECOND = 1;
    localparam int BIT_BOOT   = 2;
    localparam int BIT_HALT   = 11;
    localparam int BIT_KEEP   = 9;
    localparam int BIT_IRQ    = 13;

    localparam int INIT_MIN = 2;

    typedef struct packed {
        logic reload;
        logic init;
        logic sts1;
        logic sts2;
        logic ctrl;
        logic ien;
        logic ists;
    } wr_sel_t;

    typedef struct packed {
        logic first;
        logic second;
        logic boot;
        logic irq_sts;
    } flags_t;

    function automatic wr_sel_t decode_wr(input logic en, input logic [3:0] addr);
        wr_sel_t s;
        s.reload = en && (addr == OFS_RELOAD);
        s.init   = en && (addr == OFS_INIT);
        s.sts1   = en && (addr == OFS_STS1);
        s.sts2   = en && (addr == OFS_STS2);
        s.ctrl   = en && (addr == OFS_CTRL);
        s.ien    = en && (addr == OFS_IEN);
        s.ists   = en && (addr == OFS_ISTS);
        return s;
    endfunction

endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
    parameter int CLKS_PER_TICK = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic restart,
    output logic tick
);
    localparam int PW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_TICK - 1);

    logic [PW-1:0] pcnt;

    assign tick = !hold && (pcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || hold || restart || (pcnt == LAST)) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    generate
        if (CLKS_PER_TICK > 1) begin : g_spacing
            // R3: ticks are never back to back when a tick spans several clocks
            assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

    // R4: a held prescaler restarts from zero, so no tick right after hold
    assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (rst)
        hold |=> (CLKS_PER_TICK == 1) || !tick || hold);

endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
    parameter int CNT_W    = 6,
    parameter int INIT_RST = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign expire = tick && !reload && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CNT_W'(INIT_RST);
        end else if (reload) begin
            cnt <= init_val;
        end else if (tick) begin
            cnt <= (cnt == ONE) ? init_val : cnt - ONE;
        end
    end

    assert_reload_loads_R2: assert property (@(posedge clk) disable iff (rst)
        reload |=> cnt == $past(init_val));

    assert_expire_reloads_R7: assert property (@(posedge clk) disable iff (rst)
        expire |=> cnt == $past(init_val));

    assert_idle_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (!tick && !reload) |=> $stable(cnt));

    assert_cnt_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
        cnt != '0);

endmodule

// File: rtl/wdog_status.sv
module wdog_status
    import wdog_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   expire,
    input  logic   strap_block,
    input  logic   clr_first,
    input  logic   clr_second,
    input  logic   clr_boot,
    input  logic   clr_irq,
    input  logic   irq_en,
    output flags_t flags,
    output logic   rst_pulse
);
    logic stage2;
    logic stage1;

    assign stage2 = expire && flags.first;
    assign stage1 = expire && !flags.first;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags     <= '{first: 1'b0, second: 1'b0, boot: 1'b1, irq_sts: 1'b0};
            rst_pulse <= 1'b0;
        end else begin
            flags.first   <= expire ? 1'b1 : (clr_first ? 1'b0 : flags.first);
            flags.second  <= stage2 ? 1'b1 : (clr_second ? 1'b0 : flags.second);
            flags.boot    <= clr_boot ? 1'b0 : flags.boot;
            flags.irq_sts <= (stage1 && irq_en) ? 1'b1 : (clr_irq ? 1'b0 : flags.irq_sts);
            rst_pulse     <= stage2 && !strap_block;
        end
    end

    assert_first_set_R7: assert property (@(posedge clk) disable iff (rst)
        expire |=> flags.first);

    assert_w1c_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!expire && !clr_first) |=> $stable(flags.first));

    assert_second_set_R11: assert property (@(posedge clk) disable iff (rst)
        (expire && flags.first) |=> flags.second);

    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |=> !rst_pulse);

    assert_strap_blocks_R12: assert property (@(posedge clk) disable iff (rst)
        (expire && strap_block) |=> !rst_pulse);

    assert_boot_only_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !clr_boot |=> $stable(flags.boot));

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int CLKS_PER_TICK = 4,
    parameter int CNT_W         = 6,
    parameter int INIT_RST      = 4,
    parameter int ADDR_W        = 4,
    parameter int DATA_W        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              strap_no_reset,
    output logic              irq,
    output logic              sys_rst_pulse
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(INIT_MIN);

    wr_sel_t          sel;
    logic [CNT_W-1:0] init_q;
    logic             halt_q;
    logic             ien_q;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             expire;
    flags_t           flags;

    assign sel = decode_wr(wr_en, 4'(wr_addr));

    always_ff @(posedge clk) begin
        if (rst) begin
            init_q <= CNT_W'(INIT_RST);
            halt_q <= 1'b1;
            ien_q  <= 1'b0;
        end else begin
            if (sel.init) begin
                init_q <= (wr_data[CNT_W-1:0] < MIN_V) ? MIN_V : wr_data[CNT_W-1:0];
            end
            if (sel.ctrl) begin
                halt_q <= wr_data[BIT_HALT];
            end
            if (sel.ien) begin
                ien_q <= wr_data[BIT_IRQ];
            end
        end
    end

    wdog_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .hold    (halt_q),
        .restart (sel.reload),
        .tick    (tick)
    );

    wdog_down_counter #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .reload   (sel.reload),
        .init_val (init_q),
        .cnt      (cnt),
        .expire   (expire)
    );

    wdog_status u_sts (
        .clk         (clk),
        .rst         (rst),
        .expire      (expire),
        .strap_block (strap_no_reset),
        .clr_first   (sel.sts1 && wr_data[BIT_FIRST]),
        .clr_second  (sel.sts2 && wr_data[BIT_SECOND]),
        .clr_boot    (sel.sts2 && wr_data[BIT_BOOT]),
        .clr_irq     (sel.ists && wr_data[BIT_IRQ]),
        .irq_en      (ien_q),
        .flags       (flags),
        .rst_pulse   (sys_rst_pulse)
    );

    assign irq = flags.irq_sts && ien_q;

    always_comb begin
        rd_data = '0;
        case (4'(rd_addr))
            OFS_RELOAD: rd_data[CNT_W-1:0] = cnt;
            OFS_INIT:   rd_data[CNT_W-1:0] = init_q;
            OFS_STS1:   rd_data[BIT_FIRST] = flags.first;
            OFS_STS2: begin
                rd_data[BIT_SECOND] = flags.second;
                rd_data[BIT_BOOT]   = flags.boot;
            end
            OFS_CTRL:   rd_data[BIT_HALT] = halt_q;
            OFS_IEN:    rd_data[BIT_IRQ]  = ien_q;
            OFS_ISTS:   rd_data[BIT_IRQ]  = flags.irq_sts;
            default:    rd_data = '0;
        endcase
    end

    // R5: the preserved control bit never reads back as written
    assert_keep_bit_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADDR_W'(OFS_CTRL)) |-> !rd_data[BIT_KEEP]);

    // R10: interrupt only while enabled
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> ien_q);

endmodule

// File: tb/sim_wdog_two_stage.sv
module sim_wdog_two_stage;
    localparam int CLKS  = 4;
    localparam int INITR = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic        strap = 1'b0;
    logic [15:0] rd_data;
    logic        irq;
    logic        sys_rst;

    always #2 clk = ~clk;

    wdog_two_stage #(.CLKS_PER_TICK(CLKS), .INIT_RST(INITR)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .strap_no_reset(strap),
        .irq(irq), .sys_rst_pulse(sys_rst)
    );

    int n_vec = 0;
    int n_bad = 0;
    int pulses = 0;
    bit live = 0;
    bit done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference state
    int m_pc, m_cnt, m_init, m_halt, m_f1, m_f2, m_boot, m_ien, m_ists, m_rst;

    always @(posedge clk) begin
        if (rst) begin
            m_pc = 0; m_cnt = INITR; m_init = INITR; m_halt = 1;
            m_f1 = 0; m_f2 = 0; m_boot = 1; m_ien = 0; m_ists = 0; m_rst = 0;
        end else begin
            int rl, tk, ex, f1o, d;
            d   = wr_data;
            rl  = (wr_en && wr_addr == 4'h0) ? 1 : 0;
            tk  = (m_halt == 0 && m_pc == CLKS - 1) ? 1 : 0;
            ex  = (tk && !rl && m_cnt == 1) ? 1 : 0;
            f1o = m_f1;
            if (m_halt || rl || m_pc == CLKS - 1) m_pc = 0; else m_pc = m_pc + 1;
            if (rl) m_cnt = m_init;
            else if (tk) m_cnt = (m_cnt == 1) ? m_init : m_cnt - 1;
            m_rst = (ex && f1o && !strap) ? 1 : 0;
            if (ex) m_f1 = 1; else if (wr_en && wr_addr == 4'h4 && d[3]) m_f1 = 0;
            if (ex && f1o) m_f2 = 1; else if (wr_en && wr_addr == 4'h6 && d[1]) m_f2 = 0;
            if (wr_en && wr_addr == 4'h6 && d[2]) m_boot = 0;
            if (ex && !f1o && m_ien) m_ists = 1;
            else if (wr_en && wr_addr == 4'hC && d[13]) m_ists = 0;
            if (wr_en && wr_addr == 4'h1) m_init = ((d & 63) < 2) ? 2 : (d & 63);
            if (wr_en && wr_addr == 4'h8) m_halt = d[11];
            if (wr_en && wr_addr == 4'hA) m_ien = d[13];
        end
    end

    function automatic int exp_rd(input logic [3:0] a);
        case (a)
            4'h0: return m_cnt;
            4'h1: return m_init;
            4'h4: return m_f1 << 3;
            4'h6: return (m_boot << 2) | (m_f2 << 1);
            4'h8: return m_halt << 11;
            4'hA: return m_ien << 13;
            4'hC: return m_ists << 13;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'h0: return "R2/R3 count";
            4'h1: return "R6 init";
            4'h4: return "R7/R8 sts1";
            4'h6: return "R9/R11 sts2";
            4'h8: return "R4/R5 ctrl";
            4'hA, 4'hC: return "R10 irq regs";
            default: return "R1 unused offset";
        endcase
    endfunction

    always @(negedge clk) begin
        if (live && !done) begin
            chk(tag_of(rd_addr), int'(rd_data), exp_rd(rd_addr));
            chk("R10 irq pin", int'(irq), (m_ists && m_ien) ? 1 : 0);
            chk("R11/R12 sys_rst_pulse", int'(sys_rst), m_rst);
            if (sys_rst) pulses++;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rdchk(input logic [3:0] a, input int exp, input string tag);
        rd_addr = a;
        @(negedge clk);
        chk(tag, int'(rd_data), exp);
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        logic [3:0] seq [8] = '{4'h0, 4'h1, 4'h4, 4'h6, 4'h8, 4'hA, 4'hC, 4'h2};
        for (int i = 0; i < n; i++) begin
            rd_addr = seq[i % 8];
            @(posedge clk); #1;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        int frozen, p0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0; live = 1;

        // R1 / R9 reset state
        rdchk(4'h0, INITR, "R1 count after reset");
        rdchk(4'h8, 16'h0800, "R1 halt after reset");
        rdchk(4'h4, 0, "R1 sts1 after reset");
        rdchk(4'h6, 16'h0004, "R9 boot flag after reset");
        chk("R1 irq low", int'(irq), 0);
        chk("R1 reset pulse low", int'(sys_rst), 0);

        // R6 clamp and deferred effect
        wr(4'h1, 16'h0000);
        rdchk(4'h1, 2, "R6 init 0 stored as 2");
        wr(4'h1, 16'hFFC5);
        rdchk(4'h1, 5, "R6 init low bits only");
        rdchk(4'h0, INITR, "R6 count unchanged before reload");

        // R5 preserved bit, start running, R2 reload
        wr(4'h8, 16'h0200);
        rdchk(4'h8, 0, "R5 keep bit and halt cleared");
        wr(4'h0, 16'h1234);
        rdchk(4'h0, 5, "R2 reload loads initial value");
        wr(4'hA, 16'h2000);
        idle(22);
        rdchk(4'h4, 16'h0008, "R7 first flag set");
        chk("R10 irq raised", int'(irq), 1);
        chk("R11 no pulse on first expiry", pulses, 0);

        // R8 write-one-to-clear
        wr(4'h4, 16'h0000);
        rdchk(4'h4, 16'h0008, "R8 write 0 no effect");
        wr(4'h4, 16'h0008);
        rdchk(4'h4, 0, "R8 write 1 clears");
        wr(4'hC, 16'h2000);
        rdchk(4'hC, 0, "R10 irq status cleared");
        chk("R10 irq dropped", int'(irq), 0);

        // R3 exact tick timing, then two expiries -> R11
        wr(4'h0, 16'h0000);
        idle(CLKS - 1);
        rdchk(4'h0, 5, "R3 count before first tick");
        rdchk(4'h0, 4, "R3 count after first tick");
        idle(17);
        chk("R10 irq again on first stage", int'(irq), 1);
        idle(20);
        chk("R11 one reset pulse", pulses, 1);
        rdchk(4'h6, 16'h0006, "R11 second flag set");

        // R12 strap blocks pulse
        strap = 1'b1;
        wr(4'h6, 16'h0002);
        rdchk(4'h6, 16'h0004, "R8 second flag cleared");
        p0 = pulses;
        wr(4'h0, 16'h0000);
        idle(22);
        chk("R12 no pulse with strap", pulses, p0);
        rdchk(4'h6, 16'h0006, "R12 second flag still set");
        wr(4'h6, 16'h0004);
        rdchk(4'h6, 16'h0002, "R9 boot flag cleared by write 1");

        // R4 halt freezes count
        wr(4'h8, 16'h0800);
        rd_addr = 4'h0;
        @(negedge clk); frozen = rd_data;
        @(posedge clk); #1;
        idle(30);
        rdchk(4'h0, frozen, "R4 count frozen while halted");
        chk("R4 no pulse while halted", pulses, p0);
        wr(4'h8, 16'h0000);
        idle(3 * CLKS);
        strap = 1'b0;
        idle(50);

        finish_run();
    end
endmodule